// File: doc/BRIEF.md
# Configurable Register Output Macrocell

This block is one output cell of a small programmable logic device. It takes finished sum-of-products terms (a D or J input, a K input and a separate combinational term) along with control terms for flip-flop mode, load, preset, reset, a product-term clock and a product-term enable. It also takes the device-wide external clock and an active-low external enable. Static configuration inputs set the register type, the clock source, whether the pin is registered or bypassed, the polarity of the bypass path and where the output enable comes from.

The cell's register runs in every configuration. When the pin is bypassed to the combinational term, the register keeps stepping as a buried flip-flop with its own inputs and stays visible on its own feedback output. With the output disabled, the load term turns the pin into a clocked input: a clock event copies the pin value into the register. All logic runs on one system clock `clk`. The external clock and the product-term clock are treated as event strobes, and their rising edges are detected in the `clk` domain.

Top module: `macro_out_cell`

## Requirements
- R1: While `rst_n` is low at a `clk` edge the register is cleared, so `reg_fb` reads 0 from the next edge on.
- R2: A register clock event is a 0-to-1 change of the selected clock input between two consecutive `clk` edges. The register updates at the edge where the new value is first sampled, and in D behaviour it takes `d_j`.
- R3: In JK behaviour a clock event with (`d_j`,`k_in`) = (1,1) toggles, (1,0) sets, (0,1) clears and (0,0) holds. Without a clock event, preset or reset, the register never changes.
- R4: `cfg_regtype` 2'b00 fixes D behaviour and 2'b01 fixes JK behaviour. 2'b10 and 2'b11 are dynamic: `ff_mode` low gives D behaviour and high gives JK behaviour at that event.
- R5: `cfg_clk_pt` = 0 clocks the register from `ext_clk` and 1 clocks it from `pt_clk`. Edges on the unselected input have no effect.
- R6: With `cfg_bypass` = 1, `pin_out` equals `comb_term` XOR `cfg_invert`. The register keeps its own sequence on `reg_fb` whatever the combinational term does.
- R7: With `cfg_bypass` = 0, `pin_out` is the inverse of the register, and `cfg_invert` has no effect.
- R8: `cfg_oe_src` 2'b00 gives `pin_oe` = NOT `ext_oe_n`, 2'b01 gives `pin_oe` = `pt_oe`, 2'b10 forces it to 1 and 2'b11 forces it to 0.
- R9: A clock event with `load` high and `pin_oe` low loads `pin_in` into the register. `d_j`, `k_in`, `ff_mode` and the register type are ignored, in both registered and bypass configuration.
- R10: With `load` high but `pin_oe` high, a clock event follows the configured D/JK behaviour.
- R11: `preset` or `reset` high changes the register at the next `clk` edge without any clock event and takes priority over one. With both high the register becomes 1.
- R12: `comb_fb` equals `pin_out` while `pin_oe` is 1 and equals `pin_in` while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on clear) |
| cfg_regtype | input | 2 | Register type: 00 D, 01 JK, 1x dynamic |
| cfg_clk_pt | input | 1 | 1 = product-term clock, 0 = external clock |
| cfg_bypass | input | 1 | 1 = pin driven by the combinational term |
| cfg_invert | input | 1 | 1 = invert the combinational path |
| cfg_oe_src | input | 2 | Enable source: 00 pin, 01 term, 10 on, 11 off |
| ext_clk | input | 1 | External clock strobe |
| pt_clk | input | 1 | Product-term clock strobe |
| ext_oe_n | input | 1 | External active-low output enable |
| pt_oe | input | 1 | Product-term output enable |
| ff_mode | input | 1 | Dynamic type select: 0 D, 1 JK |
| load | input | 1 | Preload control term |
| preset | input | 1 | Register preset term |
| reset | input | 1 | Register reset term |
| d_j | input | 1 | D input, or J in JK behaviour |
| k_in | input | 1 | K input |
| comb_term | input | 1 | Combinational sum term for the bypass path |
| pin_in | input | 1 | Value seen on the pin |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin tri-state enable |
| reg_fb | output | 1 | Register feedback |
| comb_fb | output | 1 | Pin-side feedback |

## Verification
A wrong register type or a missed edge shows on `reg_fb` at the very next `clk` edge after the clock event. In registered configuration the fault also shows, inverted, on `pin_out` in the same cycle. A buried register disturbed by the bypass path differs from its expected toggle sequence at the first event after the disturbance, even while the pin looks correct. A wrong enable select shows at once on `pin_oe` and `comb_fb`. A preload that still honours the D/JK inputs leaves a register value opposite to the pin value one edge after the event.

// File: rtl/mcell_pkg.sv
// Shared encodings for the output macrocell.
// Assumes two-bit configuration codes as listed in the brief.
package mcell_pkg;

    typedef enum logic [1:0] {
        RT_D    = 2'b00,
        RT_JK   = 2'b01,
        RT_DYN  = 2'b10,
        RT_DYN2 = 2'b11
    } regtype_e;

    typedef enum logic [1:0] {
        OE_PIN  = 2'b00,
        OE_TERM = 2'b01,
        OE_ON   = 2'b10,
        OE_OFF  = 2'b11
    } oesrc_e;

    // Number of selectable register clock sources (external, product term).
    localparam int unsigned NUM_CLK_SRC = 2;
    localparam int unsigned CLK_SEL_W   = $clog2(NUM_CLK_SRC);

    // Next value of a JK flip-flop.
    function automatic logic jk_next(input logic q, input logic j, input logic k);
        return (j & ~q) | (~k & q);
    endfunction

endpackage

// File: rtl/mcell_clk_sel.sv
// Detects rising edges of each register clock source in the clk domain
// and forwards the event of the selected source.
// Assumes each source is held for at least one clk period in each level.
module mcell_clk_sel
    import mcell_pkg::*;
#(
    parameter int unsigned NSRC = NUM_CLK_SRC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         src,
    input  logic [$clog2(NSRC)-1:0] sel,
    output logic                    fire
);

    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] rise;

    // Remember each source's level from the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src;
        end
    end

    // Per-source rising-edge detect.
    for (genvar i = 0; i < NSRC; i++) begin : g_rise
        assign rise[i] = src[i] & ~src_q[i];
    end

    // Forward only the selected source's event.
    always_comb begin
        fire = rise[sel];
    end

endmodule

// File: rtl/mcell_reg.sv
// The cell's flip-flop: preset/reset priority, pin preload, and D or JK
// update on a clock event.
// Assumes the event and the behaviour select are computed by the parent.
module mcell_reg
    import mcell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic preset,
    input  logic reset,
    input  logic load_ok,
    input  logic pin_in,
    input  logic use_jk,
    input  logic d_j,
    input  logic k_in,
    output logic q
);

    logic q_next;

    // Value taken on a clock event.
    always_comb begin
        if (load_ok) begin
            q_next = pin_in;
        end else if (use_jk) begin
            q_next = jk_next(q, d_j, k_in);
        end else begin
            q_next = d_j;
        end
    end

    // Register update; preset beats reset, both beat the clock event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (preset) begin
            q <= 1'b1;
        end else if (reset) begin
            q <= 1'b0;
        end else if (fire) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/mcell_pin.sv
// Pin-side logic: output select with bypass polarity, enable source
// select, and the pin-side feedback.
// Assumes the pin reads back its own drive while enabled.
module mcell_pin
    import mcell_pkg::*;
(
    input  logic       cfg_bypass,
    input  logic       cfg_invert,
    input  logic [1:0] cfg_oe_src,
    input  logic       ext_oe_n,
    input  logic       pt_oe,
    input  logic       comb_term,
    input  logic       q,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       comb_fb
);

    oesrc_e oe_sel;

    // Output select: bypass path with polarity, or inverted register.
    always_comb begin
        if (cfg_bypass) begin
            pin_out = comb_term ^ cfg_invert;
        end else begin
            pin_out = ~q;
        end
    end

    // Output enable source select.
    always_comb begin
        oe_sel = oesrc_e'(cfg_oe_src);
        unique case (oe_sel)
            OE_PIN:  pin_oe = ~ext_oe_n;
            OE_TERM: pin_oe = pt_oe;
            OE_ON:   pin_oe = 1'b1;
            default: pin_oe = 1'b0;
        endcase
    end

    // Pin-side feedback: own drive when enabled, outside value otherwise.
    always_comb begin
        comb_fb = pin_oe ? pin_out : pin_in;
    end

endmodule

// File: rtl/macro_out_cell.sv
// Configurable register output macrocell. The register runs in every
// configuration; the pin shows either its inverse or the combinational term.
// Assumes configuration inputs are static between tests.
module macro_out_cell
    import mcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_regtype,
    input  logic       cfg_clk_pt,
    input  logic       cfg_bypass,
    input  logic       cfg_invert,
    input  logic [1:0] cfg_oe_src,
    input  logic       ext_clk,
    input  logic       pt_clk,
    input  logic       ext_oe_n,
    input  logic       pt_oe,
    input  logic       ff_mode,
    input  logic       load,
    input  logic       preset,
    input  logic       reset,
    input  logic       d_j,
    input  logic       k_in,
    input  logic       comb_term,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       reg_fb,
    output logic       comb_fb
);

    regtype_e rtype;
    logic     use_jk;
    logic     load_ok;
    logic     fire;
    logic     q;

    // Behaviour select: fixed D, fixed JK, or chosen by ff_mode.
    always_comb begin
        rtype = regtype_e'(cfg_regtype);
        unique case (rtype)
            RT_D:    use_jk = 1'b0;
            RT_JK:   use_jk = 1'b1;
            default: use_jk = ff_mode;
        endcase
    end

    // Preload only while the pin is not driven.
    always_comb begin
        load_ok = load & ~pin_oe;
    end

    mcell_clk_sel #(
        .NSRC(NUM_CLK_SRC)
    ) u_clk_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .src   ({pt_clk, ext_clk}),
        .sel   (CLK_SEL_W'(cfg_clk_pt)),
        .fire  (fire)
    );

    mcell_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .preset  (preset),
        .reset   (reset),
        .load_ok (load_ok),
        .pin_in  (pin_in),
        .use_jk  (use_jk),
        .d_j     (d_j),
        .k_in    (k_in),
        .q       (q)
    );

    mcell_pin u_pin (
        .cfg_bypass (cfg_bypass),
        .cfg_invert (cfg_invert),
        .cfg_oe_src (cfg_oe_src),
        .ext_oe_n   (ext_oe_n),
        .pt_oe      (pt_oe),
        .comb_term  (comb_term),
        .q          (q),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .comb_fb    (comb_fb)
    );

    assign reg_fb = q;

endmodule

// File: rtl/macro_out_cell_chk.sv
// Port-level checker for the macrocell, attached by bind.
// Keeps its own edge history of both clock strobes.
module macro_out_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_clk_pt,
    input logic [1:0] cfg_oe_src,
    input logic       ext_clk,
    input logic       pt_clk,
    input logic       load,
    input logic       preset,
    input logic       reset,
    input logic       pin_in,
    input logic       pin_oe,
    input logic       reg_fb,
    input logic       comb_fb
);

    logic ext_prev;
    logic pt_prev;
    logic sel_rise;

    // Previous levels of the clock strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev <= 1'b0;
            pt_prev  <= 1'b0;
        end else begin
            ext_prev <= ext_clk;
            pt_prev  <= pt_clk;
        end
    end

    assign sel_rise = cfg_clk_pt ? (pt_clk & ~pt_prev) : (ext_clk & ~ext_prev);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (reg_fb == 1'b0));

    a_r11_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> reg_fb);

    a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reset && !preset) |=> !reg_fb);

    a_r3_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !reset && !sel_rise) |=> $stable(reg_fb));

    a_r9_preload_takes_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && load && !pin_oe && !preset && !reset) |=> (reg_fb == $past(pin_in)));

    a_r8_forced_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_src[1]) |-> (pin_oe == !cfg_oe_src[0]));

    a_r12_feedback_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> (comb_fb == pin_in));

endmodule

bind macro_out_cell macro_out_cell_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_clk_pt (cfg_clk_pt),
    .cfg_oe_src (cfg_oe_src),
    .ext_clk    (ext_clk),
    .pt_clk     (pt_clk),
    .load       (load),
    .preset     (preset),
    .reset      (reset),
    .pin_in     (pin_in),
    .pin_oe     (pin_oe),
    .reg_fb     (reg_fb),
    .comb_fb    (comb_fb)
);

// File: tb/macro_out_cell_bench.sv
// Directed bench for the macrocell; one task per scenario.
module macro_out_cell_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_regtype;
    logic       cfg_clk_pt;
    logic       cfg_bypass;
    logic       cfg_invert;
    logic [1:0] cfg_oe_src;
    logic       ext_clk;
    logic       pt_clk;
    logic       ext_oe_n;
    logic       pt_oe;
    logic       ff_mode;
    logic       load;
    logic       preset;
    logic       reset;
    logic       d_j;
    logic       k_in;
    logic       comb_term;
    logic       pin_in;
    logic       pin_out;
    logic       pin_oe;
    logic       reg_fb;
    logic       comb_fb;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    macro_out_cell u_macro_out_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_regtype (cfg_regtype),
        .cfg_clk_pt  (cfg_clk_pt),
        .cfg_bypass  (cfg_bypass),
        .cfg_invert  (cfg_invert),
        .cfg_oe_src  (cfg_oe_src),
        .ext_clk     (ext_clk),
        .pt_clk      (pt_clk),
        .ext_oe_n    (ext_oe_n),
        .pt_oe       (pt_oe),
        .ff_mode     (ff_mode),
        .load        (load),
        .preset      (preset),
        .reset       (reset),
        .d_j         (d_j),
        .k_in        (k_in),
        .comb_term   (comb_term),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .reg_fb      (reg_fb),
        .comb_fb     (comb_fb)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // One event on the external clock; returns at the negedge after the update.
    task automatic ext_tick();
        @(negedge clk) ext_clk = 1'b1;
        @(negedge clk) ext_clk = 1'b0;
    endtask

    task automatic pt_tick();
        @(negedge clk) pt_clk = 1'b1;
        @(negedge clk) pt_clk = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk) reset = 1'b1;
        @(negedge clk) reset = 1'b0;
    endtask

    task automatic pulse_preset();
        @(negedge clk) preset = 1'b1;
        @(negedge clk) preset = 1'b0;
    endtask

    task automatic defaults();
        cfg_regtype = 2'b00; cfg_clk_pt = 1'b0; cfg_bypass = 1'b0;
        cfg_invert  = 1'b0;  cfg_oe_src = 2'b10;
        ext_clk = 1'b0; pt_clk = 1'b0; ext_oe_n = 1'b1; pt_oe = 1'b0;
        ff_mode = 1'b0; load = 1'b0; preset = 1'b0; reset = 1'b0;
        d_j = 1'b0; k_in = 1'b0; comb_term = 1'b0; pin_in = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reg after reset", reg_fb, 1'b0);
        chk("R1 pin after reset", pin_out, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_dtype();
        defaults();
        d_j = 1'b1; ext_tick();
        chk("R2 D load 1", reg_fb, 1'b1);
        d_j = 1'b0; repeat (3) @(negedge clk);
        chk("R3 no event holds", reg_fb, 1'b1);
        ext_tick();
        chk("R2 D load 0", reg_fb, 1'b0);
    endtask

    task automatic t_jk();
        defaults(); cfg_regtype = 2'b01;
        d_j = 1'b1; k_in = 1'b0; ext_tick(); chk("R3 JK set", reg_fb, 1'b1);
        d_j = 1'b0; k_in = 1'b0; ext_tick(); chk("R3 JK hold", reg_fb, 1'b1);
        d_j = 1'b1; k_in = 1'b1; ext_tick(); chk("R3 JK toggle 1", reg_fb, 1'b0);
        ext_tick(); chk("R3 JK toggle 2", reg_fb, 1'b1);
        d_j = 1'b0; k_in = 1'b1; ext_tick(); chk("R3 JK clear", reg_fb, 1'b0);
    endtask

    task automatic t_dynamic();
        defaults(); pulse_reset();
        cfg_regtype = 2'b10; d_j = 1'b1; k_in = 1'b1;
        ff_mode = 1'b0; ext_tick(); chk("R4 dynamic D", reg_fb, 1'b1);
        ff_mode = 1'b1; ext_tick(); chk("R4 dynamic JK toggle", reg_fb, 1'b0);
        cfg_regtype = 2'b11; d_j = 1'b0; k_in = 1'b0;
        ext_tick(); chk("R4 code 11 JK hold", reg_fb, 1'b0);
        ff_mode = 1'b0; d_j = 1'b1; k_in = 1'b0;
        ext_tick(); chk("R4 code 11 D", reg_fb, 1'b1);
    endtask

    task automatic t_clksrc();
        defaults(); pulse_reset();
        cfg_clk_pt = 1'b1; d_j = 1'b1;
        ext_tick(); chk("R5 external ignored", reg_fb, 1'b0);
        pt_tick();  chk("R5 term clock loads", reg_fb, 1'b1);
        cfg_clk_pt = 1'b0; d_j = 1'b0;
        pt_tick();  chk("R5 term clock ignored", reg_fb, 1'b1);
        ext_tick(); chk("R5 external loads", reg_fb, 1'b0);
    endtask

    task automatic t_bypass();
        logic exp_q;
        defaults(); pulse_reset();
        cfg_bypass = 1'b1; cfg_regtype = 2'b01; d_j = 1'b1; k_in = 1'b1;
        exp_q = 1'b0;
        for (int i = 0; i < 4; i++) begin
            comb_term = i[0];
            cfg_invert = i[1];
            @(negedge clk);
            chk("R6 bypass pin", pin_out, i[0] ^ i[1]);
            comb_term = ~comb_term;
            ext_tick();
            exp_q = ~exp_q;
            chk("R6 buried sequence", reg_fb, exp_q);
        end
    endtask

    task automatic t_regout();
        defaults(); pulse_preset();
        cfg_invert = 1'b1; comb_term = 1'b1;
        @(negedge clk);
        chk("R7 pin is inverse (q=1)", pin_out, 1'b0);
        pulse_reset();
        chk("R7 pin is inverse (q=0)", pin_out, 1'b1);
    endtask

    task automatic t_oe();
        defaults();
        cfg_oe_src = 2'b00; ext_oe_n = 1'b0; pt_oe = 1'b0; #1;
        chk("R8 pin enable on", pin_oe, 1'b1);
        ext_oe_n = 1'b1; pt_oe = 1'b1; #1;
        chk("R8 pin enable off", pin_oe, 1'b0);
        cfg_oe_src = 2'b01; #1;
        chk("R8 term enable on", pin_oe, 1'b1);
        pt_oe = 1'b0; ext_oe_n = 1'b0; #1;
        chk("R8 term enable off", pin_oe, 1'b0);
        cfg_oe_src = 2'b10; #1;
        chk("R8 always on", pin_oe, 1'b1);
        cfg_oe_src = 2'b11; #1;
        chk("R8 always off", pin_oe, 1'b0);
    endtask

    task automatic t_preload();
        defaults(); pulse_reset();
        cfg_oe_src = 2'b11; load = 1'b1;
        cfg_regtype = 2'b01; d_j = 1'b0; k_in = 1'b1; pin_in = 1'b1;
        ext_tick(); chk("R9 preload over JK clear", reg_fb, 1'b1);
        cfg_regtype = 2'b00; d_j = 1'b1; pin_in = 1'b0;
        ext_tick(); chk("R9 preload over D", reg_fb, 1'b0);
        cfg_bypass = 1'b1; cfg_regtype = 2'b10; ff_mode = 1'b1;
        d_j = 1'b0; k_in = 1'b0; pin_in = 1'b1;
        ext_tick(); chk("R9 preload in bypass", reg_fb, 1'b1);
    endtask

    task automatic t_load_enabled();
        defaults(); pulse_preset();
        cfg_oe_src = 2'b10; load = 1'b1; pin_in = 1'b1; d_j = 1'b0;
        ext_tick(); chk("R10 enabled load follows D", reg_fb, 1'b0);
    endtask

    task automatic t_prerst();
        defaults(); pulse_reset();
        pulse_preset(); chk("R11 preset without event", reg_fb, 1'b1);
        pulse_reset();  chk("R11 reset without event", reg_fb, 1'b0);
        @(negedge clk) begin preset = 1'b1; reset = 1'b1; end
        @(negedge clk) begin preset = 1'b0; reset = 1'b0; end
        chk("R11 both gives 1", reg_fb, 1'b1);
        d_j = 1'b1;
        @(negedge clk) begin reset = 1'b1; ext_clk = 1'b1; end
        @(negedge clk) begin reset = 1'b0; ext_clk = 1'b0; end
        chk("R11 reset beats event", reg_fb, 1'b0);
    endtask

    task automatic t_combfb();
        defaults(); cfg_bypass = 1'b1; comb_term = 1'b1; pin_in = 1'b0;
        cfg_oe_src = 2'b10; #1;
        chk("R12 feedback from drive", comb_fb, 1'b1);
        cfg_oe_src = 2'b11; #1;
        chk("R12 feedback from pin", comb_fb, 1'b0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        defaults();
        t_reset();
        t_dtype();
        t_jk();
        t_dynamic();
        t_clksrc();
        t_bypass();
        t_regout();
        t_oe();
        t_preload();
        t_load_enabled();
        t_prerst();
        t_combfb();
        summary();
    end

endmodule